// File: doc/BRIEF.md
# Half-Bridge Dead-Time Interlock Generator

This block turns two logic commands, one for the high-side switch and one for the low-side switch of a half bridge, into two gate-enable outputs. The outputs are never high in the same cycle. Every turn-on is held back by a programmable number of clock cycles. Every turn-off follows the command after the synchroniser latency and nothing else. A command that asks for both switches at once produces no drive on either side.

The dead time is a clock-cycle count on a parameter-wide input. It takes the place of an external timing resistor. At a 200 MHz clock one cycle is 5 ns, so settings of 10 to 500 give about 50 ns to 2.5 µs. The two commands pass through a two-stage synchroniser before the interlock. A force-low input from a protection supervisor, which must be synchronous to the clock, blanks both outputs and clears both dead-time counts. The asynchronous active-low reset is released into the block through a two-flop reset synchroniser.

Top module: `deadtime_interlock`

## Requirements
- R1: `gate_a` and `gate_b` are never both 1 in the same cycle.
- R2: While both synchronised commands are 1, both outputs are 0 from the following cycle on.
- R3: With both commands at 0, both outputs settle to 0 and stay there.
- R4: From idle, with `dt_count` = D (unsigned, in cycles), a command on one side that is set before clock edge k drives the matching output to 1 at edge k+2+D. The other output stays 0.
- R5: When a command drops before edge k, its output goes to 0 at edge k+2. No dead time is added to a falling edge.
- R6: At a handover, where one command falls and the other rises before the same edge, the rising side reaches 1 exactly D+1 cycles after the falling side reaches 0.
- R7: If a request drops before its dead time expires, the count restarts. A pulse shorter than the dead time never drives the output, and the next request waits a full D cycles again.
- R8: With D = 0, an output rises on the clock edge after the one at which the opposite output is seen low.
- R9: `force_low` = 1 at edge k makes both outputs 0 after edge k and clears the counts. After release before edge k, a standing request rises at edge k+D.
- R10: While `rst_n` is 0, both outputs are 0. After `rst_n` rises, a command already held at 1 drives its output at the (5+D)th rising clock edge.
- R11: The full `dt_count` range applies. A setting of 500 delays a rise by 500 cycles beyond the synchroniser latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_a | input | 1 | High-side command (asynchronous) |
| cmd_b | input | 1 | Low-side command (asynchronous) |
| dt_count | input | DT_W | Dead time in clock cycles, unsigned |
| force_low | input | 1 | Synchronous protection blanking, 1 forces both outputs low |
| gate_a | output | 1 | High-side gate enable |
| gate_b | output | 1 | Low-side gate enable |

## Verification
The embedded properties assume that `force_low` is synchronous to `clk`. They also assume that `dt_count` is held steady while a dead-time count is running, because the counter compares against the live value. The bench meets both conditions by driving every input on the falling clock edge. It changes `dt_count` only while the outputs are settled, either idle or already high. Command pulses and handovers are then timed so that each exact rise and fall edge can be checked against counts derived from the requirements.

// File: rtl/dti_pkg.sv
package dti_pkg;
  localparam int NUM_SIDES = 2;
  typedef logic [NUM_SIDES-1:0] side_vec_t;

  function automatic int opposite(input int side);
    return NUM_SIDES - 1 - side;
  endfunction
endpackage

// File: rtl/dti_rst_sync.sv
module dti_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] rs_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) rs_q <= 2'b00;
    else          rs_q <= {rs_q[0], 1'b1};
  end

  assign rst_n_o = rs_q[1];
endmodule

// File: rtl/dti_sync.sv
module dti_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/dti_channel.sv
module dti_channel #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic             other_i,
  input  logic [CNT_W-1:0] dt_i,
  output logic             gate_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             gate_q, gate_d;
  logic             cnt_en;

  always_comb begin
    gate_d = gate_q;
    cnt_d  = cnt_q;
    if (!req_i) begin
      gate_d = 1'b0;
      cnt_d  = '0;
    end else if (gate_q || other_i) begin
      cnt_d  = '0;
    end else if (cnt_q >= dt_i) begin
      gate_d = 1'b1;
      cnt_d  = '0;
    end else begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  assign cnt_en = (cnt_d != cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      gate_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      gate_q <= gate_d;
    end
  end

  assign gate_o = gate_q;

  // R6: a rise only follows a cycle in which the opposite gate was low
  assert_rise_after_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_o) |-> !$past(other_i));

  // R5: a withdrawn request turns the gate off with no dead time
  assert_fall_immediate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> !gate_o);
endmodule

// File: rtl/deadtime_interlock.sv
module deadtime_interlock
  import dti_pkg::*;
#(
  parameter int DT_W        = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_a,
  input  logic            cmd_b,
  input  logic [DT_W-1:0] dt_count,
  input  logic            force_low,
  output logic            gate_a,
  output logic            gate_b
);
  logic      rst_n_s;
  side_vec_t cmd_raw, cmd_s, req, gates;

  dti_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  assign cmd_raw = {cmd_b, cmd_a};

  dti_sync #(.W(NUM_SIDES), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_s),
    .d_i   (cmd_raw),
    .q_o   (cmd_s)
  );

  for (genvar i = 0; i < NUM_SIDES; i++) begin : g_side
    localparam int OPP = opposite(i);

    assign req[i] = cmd_s[i] & ~cmd_s[OPP] & ~force_low;

    dti_channel #(.CNT_W(DT_W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n_s),
      .req_i   (req[i]),
      .other_i (gates[OPP]),
      .dt_i    (dt_count),
      .gate_o  (gates[i])
    );
  end

  assign gate_a = gates[0];
  assign gate_b = gates[1];

  // R1: outputs mutually exclusive
  assert_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_a && gate_b));

  // R2: both commands high blanks both sides
  assert_both_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_s[0] && cmd_s[1]) |=> (!gate_a && !gate_b));

  // R9: protection blanking takes effect after one edge
  assert_force_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    force_low |=> (!gate_a && !gate_b));
endmodule

// File: tb/sim_deadtime_interlock.sv
module sim_deadtime_interlock;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_a, cmd_b, force_low;
  logic [9:0] dt_count;
  logic       gate_a, gate_b;

  int checks = 0;
  int fails  = 0;
  int excl_viol = 0;

  always #2 clk = ~clk;

  deadtime_interlock #(.DT_W(10), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_a(cmd_a), .cmd_b(cmd_b),
    .dt_count(dt_count), .force_low(force_low),
    .gate_a(gate_a), .gate_b(gate_b)
  );

  typedef struct packed {
    logic       a;
    logic       b;
    logic       fl;
    logic [9:0] dt;
    logic [7:0] hold;
    logic       ea;
    logic       eb;
  } vec_t;

  localparam vec_t VECS [0:7] = '{
    '{1'b0, 1'b0, 1'b0, 10'd4, 8'd12, 1'b0, 1'b0},
    '{1'b1, 1'b0, 1'b0, 10'd4, 8'd12, 1'b1, 1'b0},
    '{1'b1, 1'b1, 1'b0, 10'd4, 8'd12, 1'b0, 1'b0},
    '{1'b0, 1'b1, 1'b0, 10'd7, 8'd16, 1'b0, 1'b1},
    '{1'b0, 1'b1, 1'b1, 10'd7, 8'd4,  1'b0, 1'b0},
    '{1'b1, 1'b0, 1'b0, 10'd2, 8'd12, 1'b1, 1'b0},
    '{1'b0, 1'b0, 1'b0, 10'd2, 8'd6,  1'b0, 1'b0},
    '{1'b1, 1'b1, 1'b1, 10'd0, 8'd6,  1'b0, 1'b0}
  };
  localparam string TAGS [0:7] = '{"R3", "R4", "R2", "R4", "R9", "R6", "R5", "R2"};

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input logic a, input logic b, input logic fl);
    cmd_a = a; cmd_b = b; force_low = fl;
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, 1'b0);
    step(4);
  endtask

  // R1 monitor, sampled away from the active edge
  always @(negedge clk) if (gate_a && gate_b) excl_viol++;

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    drive(1'b1, 1'b0, 1'b0);
    dt_count = 10'd3;
    step(3);
    // R10 reset state
    chk("R10 gate_a in reset", gate_a, 1'b0);
    chk("R10 gate_b in reset", gate_b, 1'b0);
    rst_n = 1'b1;
    step(7);
    chk("R10 gate_a before 5+D edges", gate_a, 1'b0);
    step(1);
    chk("R10 gate_a at 5+D edges", gate_a, 1'b1);
    idle();

    // table walk
    for (int i = 0; i < 8; i++) begin
      dt_count = VECS[i].dt;
      drive(VECS[i].a, VECS[i].b, VECS[i].fl);
      step(int'(VECS[i].hold));
      chk({TAGS[i], " gate_a"}, gate_a, VECS[i].ea);
      chk({TAGS[i], " gate_b"}, gate_b, VECS[i].eb);
    end
    idle();

    // R4 exact rise timing, D=5
    dt_count = 10'd5;
    drive(1'b1, 1'b0, 1'b0);
    step(7);
    chk("R4 gate_a before k+2+D", gate_a, 1'b0);
    step(1);
    chk("R4 gate_a at k+2+D", gate_a, 1'b1);
    chk("R4 gate_b stays low", gate_b, 1'b0);

    // R6 handover A -> B, D=5
    drive(1'b0, 1'b1, 1'b0);
    step(2);
    chk("R5 gate_a still high before k+2", gate_a, 1'b1);
    step(1);
    chk("R5 gate_a low at k+2", gate_a, 1'b0);
    step(5);
    chk("R6 gate_b low D cycles after a falls", gate_b, 1'b0);
    step(1);
    chk("R6 gate_b high D+1 cycles after a falls", gate_b, 1'b1);
    idle();

    // R7 short pulse never drives, D=10
    dt_count = 10'd10;
    drive(1'b1, 1'b0, 1'b0);
    step(5);
    drive(1'b0, 1'b0, 1'b0);
    step(15);
    chk("R7 short pulse kept low", gate_a, 1'b0);
    // R7 restart after a one-cycle gap
    drive(1'b1, 1'b0, 1'b0);
    step(8);
    drive(1'b0, 1'b0, 1'b0);
    step(1);
    drive(1'b1, 1'b0, 1'b0);
    step(12);
    chk("R7 restarted count not yet expired", gate_a, 1'b0);
    step(1);
    chk("R7 restarted count expired", gate_a, 1'b1);
    idle();

    // R8 zero dead time
    dt_count = 10'd0;
    drive(1'b1, 1'b0, 1'b0);
    step(2);
    chk("R8 gate_a before k+2", gate_a, 1'b0);
    step(1);
    chk("R8 gate_a at k+2", gate_a, 1'b1);
    drive(1'b0, 1'b1, 1'b0);
    step(3);
    chk("R8 gate_a low", gate_a, 1'b0);
    chk("R8 gate_b not yet", gate_b, 1'b0);
    step(1);
    chk("R8 gate_b next edge", gate_b, 1'b1);

    // R9 force-low and release, D=6
    dt_count = 10'd6;
    drive(1'b0, 1'b1, 1'b1);
    step(1);
    chk("R9 gate_b forced low", gate_b, 1'b0);
    step(3);
    drive(1'b0, 1'b1, 1'b0);
    step(6);
    chk("R9 gate_b before release+D", gate_b, 1'b0);
    step(1);
    chk("R9 gate_b at release+D", gate_b, 1'b1);
    idle();

    // R11 large setting
    dt_count = 10'd500;
    drive(1'b1, 1'b0, 1'b0);
    step(502);
    chk("R11 gate_a before 500-cycle dead time", gate_a, 1'b0);
    step(1);
    chk("R11 gate_a after 500-cycle dead time", gate_a, 1'b1);
    idle();

    chk("R1 outputs never both high", excl_viol == 0, 1'b1);

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule